// File: doc/BRIEF.md
# Strobed Bus Master Cycle Sequencer

This block turns simple transfer requests into the half-clock-state sequence of an asynchronous-handshake 16-bit bus cycle. A requester presents an address, write data, a read/write flag and a byte/word flag. The block then runs the bus through states S0 to S7. It drives the word address, an active-low address strobe, a read/write line, active-low upper and lower data strobes and the write data. It reports completion with a one-clock done pulse. On a read, the read data is returned with that pulse.

The block is clocked by a state clock at twice the bus clock rate, so each rising edge advances exactly one state. A slow slave stretches the cycle by holding the active-low acknowledge input high. While the block sees acknowledge high at its sample point, it loops back through S4 and S5. Each pass adds one bus clock, which is two state clocks. A slave that ties acknowledge low permanently gets full-speed cycles.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, address strobe, both data strobes and read/write are high, the write drive is off, done is low and the request port is ready.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. With no wait states, done is high in the 8th state clock after the accepting edge. The sequence is S0 through S7, followed by one cycle for done.
- R3: Acknowledge is sampled on the edge that enters S5. If it is high there, the sequence goes from S5 back to S4, and the data strobes stay asserted. Each such wait adds exactly 2 state clocks to the cycle length.
- R4: On a write, read/write goes low in the same state clock as the address strobe (S2). On a read, read/write stays high and the data drive stays off.
- R5: On a write, the data strobes first assert in S4, two state clocks after the address strobe. Whenever a strobe is active, bus_doe is high and the write data is on bus_dout.
- R6: On a read, the data strobes assert together with the address strobe in S2.
- R7: A word transfer asserts both strobes. A byte transfer with address bit 0 equal to 0 asserts only the upper strobe (uds_n, data bits 15:8). A byte transfer with address bit 0 equal to 1 asserts only the lower strobe (lds_n, bits 7:0).
- R8: Read data is captured from bus_din on the single edge that enters S7. A word read returns bits 15:0. A byte read returns the addressed lane in rdata bits 7:0, with bits 15:8 set to zero.
- R9: A byte write places req_wdata bits 7:0 on both halves of bus_dout.
- R10: After S7, in the cycle where done pulses for exactly one clock, both strobes and read/write are high and the drive is off. While a cycle runs, req_ready is low and req_valid is ignored.
- R11: bus_addr carries req_addr bits ADDR_W-1:1. It holds that value for the whole time the address strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one bus state per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data, valid with done |
| bus_addr | output | ADDR_W-1 | Word address on the bus |
| as_n | output | 1 | Address strobe, active low |
| rw_n | output | 1 | High = read, low = write |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| dtack_n | input | 1 | Transfer acknowledge from slave, active low |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Data bus as seen by the master |

## Verification
The checker verifies, on every cycle, how the strobes and the read/write line relate to each other:
- read/write falls only together with the address strobe;
- data strobes appear only inside the address strobe;
- for writes, the strobes start after the address strobe, and the drive is on while they are active;
- for reads, the strobes start with the address strobe;
- the address holds steady;
- done is a one-clock pulse that coincides with all lines released.

Only the directed scenarios can show behaviour that needs knowledge of the slave's timing:
- the exact clock counts for 0, 1 and 3 wait states;
- the single edge on which read data is captured;
- the byte-lane selection and the replication of write bytes;
- the fact that requests made during a busy cycle leave no trace.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_S0   = 4'd1,
    ST_S1   = 4'd2,
    ST_S2   = 4'd3,
    ST_S3   = 4'd4,
    ST_S4   = 4'd5,
    ST_S5   = 4'd6,
    ST_S6   = 4'd7,
    ST_S7   = 4'd8
  } seq_state_e;

  // States in which the address strobe is active.
  function automatic logic in_addr_phase(seq_state_e s);
    return (s == ST_S2) || (s == ST_S3) || (s == ST_S4) ||
           (s == ST_S5) || (s == ST_S6) || (s == ST_S7);
  endfunction

  // States from S3 onward (write data driven).
  function automatic logic in_drive_phase(seq_state_e s);
    return (s == ST_S3) || (s == ST_S4) || (s == ST_S5) ||
           (s == ST_S6) || (s == ST_S7);
  endfunction

  // States from S4 onward (write strobes).
  function automatic logic in_late_phase(seq_state_e s);
    return (s == ST_S4) || (s == ST_S5) || (s == ST_S6) || (s == ST_S7);
  endfunction

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dtack_n,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       done_q
);

  logic ack_q;
  logic ack_en;

  // Acknowledge is sampled on the edge that leaves S4 and enters S5.
  assign ack_en = (state_q == ST_S4);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = ST_S4;
      ST_S4:   state_d = ST_S5;
      ST_S5:   state_d = ack_q ? ST_S6 : ST_S4;
      ST_S6:   state_d = ST_S7;
      ST_S7:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_S7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
    end else if (ack_en) begin
      ack_q <= ~dtack_n;
    end
  end

endmodule

// File: rtl/bseq_drive.sv
module bseq_drive
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_state_e        state_d,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              as_n,
  output logic              rw_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              cur_word,
  output logic              cur_a0
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  // Latched request
  logic              we_q;
  logic              word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // Request as seen for the next state (new one on accept)
  logic              we_nx;
  logic              word_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] wdata_nx;

  assign we_nx    = accept ? req_we    : we_q;
  assign word_nx  = accept ? req_word  : word_q;
  assign addr_nx  = accept ? req_addr  : addr_q;
  assign wdata_nx = accept ? req_wdata : wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign cur_word = word_q;
  assign cur_a0   = addr_q[0];
  assign bus_addr = addr_q[ADDR_W-1:1];

  // Next values of the control lines
  logic as_act_d;
  logic rw_low_d;
  logic ds_phase_d;
  logic doe_d;

  assign as_act_d   = in_addr_phase(state_d);
  assign rw_low_d   = we_nx & in_addr_phase(state_d);
  assign ds_phase_d = we_nx ? in_late_phase(state_d) : in_addr_phase(state_d);
  assign doe_d      = we_nx & in_drive_phase(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_n    <= 1'b1;
      rw_n    <= 1'b1;
      bus_doe <= 1'b0;
    end else begin
      as_n    <= ~as_act_d;
      rw_n    <= ~rw_low_d;
      bus_doe <= doe_d;
    end
  end

  // Per-lane strobe and data: lane 1 = upper (bits 15:8), lane 0 = lower.
  logic [LANES-1:0] ds_n_q;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic              hit_d;
    logic [LANE_W-1:0] data_d;

    // Byte address bit 0 = 0 selects the upper lane.
    assign hit_d  = word_nx | (addr_nx[0] == ((ln == LANES - 1) ? 1'b0 : 1'b1));
    assign data_d = word_nx ? wdata_nx[ln*LANE_W +: LANE_W] : wdata_nx[LANE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ds_n_q[ln] <= 1'b1;
      end else begin
        ds_n_q[ln] <= ~(ds_phase_d & hit_d);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bus_dout[ln*LANE_W +: LANE_W] <= '0;
      end else if (doe_d) begin
        bus_dout[ln*LANE_W +: LANE_W] <= data_d;
      end
    end
  end

  assign uds_n = ds_n_q[LANES-1];
  assign lds_n = ds_n_q[0];

endmodule

// File: rtl/bseq_capture.sv
module bseq_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              word,
  input  logic              a0,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (word) begin
      rdata_d = bus_din;
    end else if (a0) begin
      rdata_d = {{LANE_W{1'b0}}, bus_din[LANE_W-1:0]};
    end else begin
      rdata_d = {{LANE_W{1'b0}}, bus_din[DATA_W-1:LANE_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              as_n,
  output logic              rw_n,
  output logic              uds_n,
  output logic              lds_n,
  input  logic              dtack_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  seq_state_e state_q;
  seq_state_e state_d;
  logic       accept;
  logic       cur_word;
  logic       cur_a0;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;

  bseq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (accept),
    .dtack_n (dtack_n),
    .state_q (state_q),
    .state_d (state_d),
    .done_q  (done)
  );

  bseq_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_we    (req_we),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state_d   (state_d),
    .bus_addr  (bus_addr),
    .as_n      (as_n),
    .rw_n      (rw_n),
    .uds_n     (uds_n),
    .lds_n     (lds_n),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .cur_word  (cur_word),
    .cur_a0    (cur_a0)
  );

  bseq_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_en  (state_q == ST_S6),
    .word    (cur_word),
    .a0      (cur_a0),
    .bus_din (bus_din),
    .rdata_q (rdata)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-2:0] bus_addr,
  input logic              as_n,
  input logic              rw_n,
  input logic              uds_n,
  input logic              lds_n,
  input logic              bus_doe
);

  assert_rw_with_as_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rw_n) |-> $fell(as_n));

  assert_read_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_n |-> !bus_doe);

  assert_write_ds_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && !rw_n) |-> (uds_n && lds_n));

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_n && (!uds_n || !lds_n)) |-> bus_doe);

  assert_read_ds_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(as_n) && rw_n) |-> !(uds_n && lds_n));

  assert_ds_inside_as_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uds_n || !lds_n) |-> !as_n);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && uds_n && lds_n && rw_n && !bus_doe));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !req_ready);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$fell(as_n)) |-> $stable(bus_addr));

endmodule

bind bus_cycle_seq bseq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_ready (req_ready),
  .done      (done),
  .bus_addr  (bus_addr),
  .as_n      (as_n),
  .rw_n      (rw_n),
  .uds_n     (uds_n),
  .lds_n     (lds_n),
  .bus_doe   (bus_doe)
);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_we;
  logic              req_word;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              done;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-2:0] bus_addr;
  logic              as_n, rw_n, uds_n, lds_n;
  logic              dtack_n;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_doe;
  logic [DATA_W-1:0] bus_din;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .as_n(as_n), .rw_n(rw_n), .uds_n(uds_n), .lds_n(lds_n),
    .dtack_n(dtack_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  // Slave model: counts state clocks since the address strobe fell.
  int               sl_cnt  = 0;
  int               sl_wait = 0;
  bit               sl_tied = 0;
  logic [DATA_W-1:0] sl_data = '0;

  always @(negedge clk) begin
    if (!as_n) sl_cnt = sl_cnt + 1;
    else       sl_cnt = 0;
    dtack_n = sl_tied ? 1'b0 : (sl_cnt < 3 + 2 * sl_wait);
    bus_din = (sl_cnt == 5 + 2 * sl_wait) ? sl_data : ~sl_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(as_n === 1'b1 && uds_n === 1'b1 && lds_n === 1'b1 && rw_n === 1'b1,
        "R1", "strobes idle", {as_n, uds_n, lds_n, rw_n}, 4'hF);
    chk(bus_doe === 1'b0 && done === 1'b0, "R1", "drive/done idle",
        {bus_doe, done}, 0);
    chk(req_ready === 1'b1, "R1", "ready", req_ready, 1);
  endtask

  task automatic xfer(input bit we, input bit word, input logic [ADDR_W-1:0] addr,
                      input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] rbus,
                      input int w, input bit tied, input bit poke, input string tag);
    int n = 0;
    int as_first = -1;
    int rw_first = -1;
    int ds_first = -1;
    int ds_cnt = 0;
    bit bad_lane = 0, bad_data = 0, bad_addr = 0, bad_idle = 0;
    logic [1:0]        exp_ds;
    logic [DATA_W-1:0] exp_dout, exp_rd;
    exp_ds   = word ? 2'b00 : (addr[0] ? 2'b10 : 2'b01);
    exp_dout = word ? wd : {wd[7:0], wd[7:0]};
    exp_rd   = word ? rbus : (addr[0] ? {8'h00, rbus[7:0]} : {8'h00, rbus[15:8]});
    sl_wait = w; sl_tied = tied; sl_data = rbus;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_word = word; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (poke && n >= 1 && n <= 5) begin
        req_valid = 1'b1; req_addr = addr ^ 24'h00F0F1; req_we = ~we;
      end else begin
        req_valid = 1'b0;
      end
      if (done) break;
      if (!as_n && as_first < 0) as_first = n;
      if (!rw_n && rw_first < 0) rw_first = n;
      if (!uds_n || !lds_n) begin
        ds_cnt++;
        if (ds_first < 0) ds_first = n;
        if ({uds_n, lds_n} !== exp_ds) bad_lane = 1;
        if (we && (bus_doe !== 1'b1 || bus_dout !== exp_dout)) bad_data = 1;
      end
      if (!as_n && bus_addr !== addr[ADDR_W-1:1]) bad_addr = 1;
      @(posedge clk);
      n++;
    end
    chk(n == 8 + 2 * w, "R2 R3", {tag, " clocks to done"}, n, 8 + 2 * w);
    chk(as_first == 2, "R2", {tag, " strobe state"}, as_first, 2);
    chk(rw_first == (we ? 2 : -1), "R4", {tag, " rw low"}, rw_first, we ? 2 : -1);
    chk(ds_first == (we ? 4 : 2), we ? "R5" : "R6", {tag, " ds start"},
        ds_first, we ? 4 : 2);
    chk(ds_cnt == 8 + 2 * w - ds_first, "R3", {tag, " ds held through waits"},
        ds_cnt, 8 + 2 * w - ds_first);
    chk(!bad_lane, "R7", {tag, " lane select"}, bad_lane, 0);
    if (we) chk(!bad_data, word ? "R5" : "R9", {tag, " write data"}, bad_data, 0);
    else    chk(rdata === exp_rd, "R8", {tag, " read data"}, rdata, exp_rd);
    chk(!bad_addr, "R11", {tag, " address"}, bad_addr, 0);
    chk(as_n && uds_n && lds_n && rw_n && !bus_doe, "R10", {tag, " released"},
        {as_n, uds_n, lds_n, rw_n, bus_doe}, 5'b11110);
    @(negedge clk);
    chk(done === 1'b0, "R10", {tag, " done pulse width"}, done, 0);
    if (poke) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (!as_n) bad_idle = 1;
      end
      chk(!bad_idle, "R10", {tag, " busy request ignored"}, bad_idle, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; dtack_n = 1'b1; bus_din = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    test_reset();
    xfer(0, 1, 24'h001000, 16'h0000, 16'hBEEF, 0, 1, 0, "word read tied");
    xfer(1, 1, 24'h002002, 16'h1234, 16'h0000, 1, 0, 0, "word write 1w");
    xfer(0, 0, 24'h003010, 16'h0000, 16'hA55A, 3, 0, 0, "byte read upper 3w");
    xfer(0, 0, 24'h003011, 16'h0000, 16'hC33C, 0, 0, 0, "byte read lower");
    xfer(1, 0, 24'h004020, 16'h00E7, 16'h0000, 0, 0, 0, "byte write upper");
    xfer(1, 0, 24'h004021, 16'h0081, 16'h0000, 3, 0, 0, "byte write lower 3w");
    xfer(0, 1, 24'h7FFFFE, 16'h0000, 16'h5AA5, 1, 0, 1, "word read busy poke");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule